// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port reached through a simple 32-bit register bus. Software sets an output value and a per-pin drive enable, and reads back the synchronised level of every pad. Each pin also feeds an interrupt detector. The detector can trigger on a low level, a high level, a rising edge or a falling edge. A per-pin override makes the pin trigger on any change.

Detected events set sticky pending flags. Software clears a flag by writing a one to it. A mask register selects which pending flags reach the two interrupt lines. One line serves the lower half of the port and the other serves the upper half. Both lines are registered.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero. `pin_oe_o`, `pin_out_o`, `irq_lo_o` and `irq_hi_o` are all zero.
- R2: The register at byte offset 0x00 holds output data and drives `pin_out_o`. The register at 0x04 holds the direction and drives `pin_oe_o`, where 1 means the pin is driven. Both registers read back what was written.
- R3: A read of offset 0x08 returns `pin_in_i` as seen after a two-flop synchroniser. Writes to 0x08 change nothing.
- R4: Each pin n has a 2-bit trigger field at bit position 2*(n mod 16). Pins 0 to 15 use the register at 0x0C and pins 16 to 31 use the register at 0x10. The field codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge.
- R5: A pin in a level mode sets its pending bit on every cycle its synchronised level matches. This includes the cycle in which a clear is written.
- R6: A pin in an edge mode sets its pending bit once for a transition in the chosen direction. The opposite transition and a steady level set nothing.
- R7: When bit n of the register at 0x1C is 1, pin n flags on both rising and falling transitions and its trigger field is ignored.
- R8: Pending bits are read at 0x18 and stay set until cleared. Writing 1 to a bit there clears it, and writing 0 leaves it unchanged.
- R9: The mask at 0x14 does not stop pending bits from being set. Only bits that are both pending and unmasked reach an interrupt line.
- R10: `irq_lo_o` is the OR of the masked pending bits 0 to 15. `irq_hi_o` is the same for bits 16 to 31. Each line follows the pending and mask state one cycle later.
- R11: Read data appears on `bus_rdata_o` in the cycle after `bus_rd_i`. Reads of offsets 0x20 and above, and of offsets that are not word aligned, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 32 | Pad input levels |
| pin_out_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad drive enables |
| irq_lo_o | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi_o | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The bench builds the block with its defaults: 32 pins, a 6-bit address and two synchroniser stages. With 32 pins, the last pin of each half and the first pin of the upper half can be tested, which checks the split between the two configuration registers and between the two interrupt lines. The 6-bit address reaches past the eight mapped words, so the zero read-back of unmapped space can be tested.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // word indices of the register file
  localparam int unsigned IDX_DATA  = 0;
  localparam int unsigned IDX_DIR   = 1;
  localparam int unsigned IDX_PAD   = 2;
  localparam int unsigned IDX_CFGLO = 3;
  localparam int unsigned IDX_CFGHI = 4;
  localparam int unsigned IDX_MASK  = 5;
  localparam int unsigned IDX_PEND  = 6;
  localparam int unsigned IDX_ANY   = 7;
  localparam int unsigned NUM_REGS  = 8;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
      if (rst)                settle_q <= '0;
      else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end
    // R3: pad level is the input two clocks earlier
    a_r3_sync_delay: assert property (@(posedge clk) disable iff (rst)
      (settle_q == 2'd3) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] lvl_i,
  input  logic [PINS-1:0] cfg_lo_i,
  input  logic [PINS-1:0] cfg_hi_i,
  input  logic [PINS-1:0] any_i,
  output logic [PINS-1:0] evt_o
);
  import gpio_irq_pkg::*;
  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) prv_q <= '0;
    else     prv_q <= lvl_i;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] code;
    logic       cur, prv, hit;
    if (i < HALF) begin : g_lo
      assign code = cfg_lo_i[2*i +: 2];
    end else begin : g_hi
      assign code = cfg_hi_i[2*(i-HALF) +: 2];
    end
    assign cur = lvl_i[i];
    assign prv = prv_q[i];
    always_comb begin
      unique case (trig_e'(code))
        TRIG_LOW:  hit = ~cur;
        TRIG_HIGH: hit = cur;
        TRIG_RISE: hit = cur & ~prv;
        TRIG_FALL: hit = ~cur & prv;
        default:   hit = 1'b0;
      endcase
    end
    assign evt_o[i] = any_i[i] ? (cur ^ prv) : hit;
  end

  // R7: a pin in any-change mode flags nothing while steady
  a_r7_any_quiet: assert property (@(posedge clk) disable iff (rst)
    ((evt_o & any_i & ~(lvl_i ^ prv_q)) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PINS-1:0]   wdata_i,
  output logic [PINS-1:0]   rdata_o,
  input  logic [PINS-1:0]   pad_i,
  input  logic [PINS-1:0]   evt_i,
  output logic [PINS-1:0]   data_o,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   cfg_lo_o,
  output logic [PINS-1:0]   cfg_hi_o,
  output logic [PINS-1:0]   mask_o,
  output logic [PINS-1:0]   any_o,
  output logic [PINS-1:0]   pend_o
);
  import gpio_irq_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DATA  = WORD_W'(IDX_DATA);
  localparam logic [WORD_W-1:0] W_DIR   = WORD_W'(IDX_DIR);
  localparam logic [WORD_W-1:0] W_PAD   = WORD_W'(IDX_PAD);
  localparam logic [WORD_W-1:0] W_CFGLO = WORD_W'(IDX_CFGLO);
  localparam logic [WORD_W-1:0] W_CFGHI = WORD_W'(IDX_CFGHI);
  localparam logic [WORD_W-1:0] W_MASK  = WORD_W'(IDX_MASK);
  localparam logic [WORD_W-1:0] W_PEND  = WORD_W'(IDX_PEND);
  localparam logic [WORD_W-1:0] W_ANY   = WORD_W'(IDX_ANY);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic [PINS-1:0]   clr, rd_mux;
  logic [PINS-1:0]   data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, any_q, pend_q, rdata_q;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign clr     = (wr_i && aligned && word == W_PEND) ? wdata_i : '0;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (word)
        W_DATA:  rd_mux = data_q;
        W_DIR:   rd_mux = dir_q;
        W_PAD:   rd_mux = pad_i;
        W_CFGLO: rd_mux = cfg_lo_q;
        W_CFGHI: rd_mux = cfg_hi_q;
        W_MASK:  rd_mux = mask_q;
        W_PEND:  rd_mux = pend_q;
        W_ANY:   rd_mux = any_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      any_q    <= '0;
      pend_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_i && aligned) begin
        unique case (word)
          W_DATA:  data_q   <= wdata_i;
          W_DIR:   dir_q    <= wdata_i;
          W_CFGLO: cfg_lo_q <= wdata_i;
          W_CFGHI: cfg_hi_q <= wdata_i;
          W_MASK:  mask_q   <= wdata_i;
          W_ANY:   any_q    <= wdata_i;
          default: ;
        endcase
      end
      // a fresh event wins over a clear in the same cycle
      pend_q  <= (pend_q & ~clr) | evt_i;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign data_o   = data_q;
  assign dir_o    = dir_q;
  assign cfg_lo_o = cfg_lo_q;
  assign cfg_hi_o = cfg_hi_q;
  assign mask_o   = mask_q;
  assign any_o    = any_q;
  assign pend_o   = pend_q;
  assign rdata_o  = rdata_q;

  // R8: a pending bit only drops when a one is written to it
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr)) == '0));
  // R8: a cleared bit with no new event reads zero next cycle
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((pend_q & $past(clr & ~evt_i)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [PINS-1:0]   bus_wdata_i,
  output logic [PINS-1:0]   bus_rdata_o,
  input  logic [PINS-1:0]   pin_in_i,
  output logic [PINS-1:0]   pin_out_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0] lvl, evt, cfg_lo, cfg_hi, mask, any, pend, live;
  logic            irq_lo_q, irq_hi_q;

  gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in_i), .dout(lvl));

  gpio_irq_detect #(.PINS(PINS)) u_detect (
    .clk(clk), .rst(rst), .lvl_i(lvl), .cfg_lo_i(cfg_lo), .cfg_hi_i(cfg_hi),
    .any_i(any), .evt_o(evt));

  gpio_irq_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .pad_i(lvl), .evt_i(evt),
    .data_o(pin_out_o), .dir_o(pin_oe_o), .cfg_lo_o(cfg_lo), .cfg_hi_o(cfg_hi),
    .mask_o(mask), .any_o(any), .pend_o(pend));

  assign live = pend & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      irq_lo_q <= |live[HALF-1:0];
      irq_hi_q <= |live[PINS-1:HALF];
    end
  end

  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;

  // R9: a fully masked half never raises its line
  a_r9_lo_masked: assert property (@(posedge clk) disable iff (rst)
    (mask[HALF-1:0] == '0) |=> !irq_lo_o);
  a_r9_hi_masked: assert property (@(posedge clk) disable iff (rst)
    (mask[PINS-1:HALF] == '0) |=> !irq_hi_o);
  // R10: a line rises only after pending state in its own half
  a_r10_lo_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_lo_o) |-> ($past(pend[HALF-1:0]) != '0));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {pin[4:0], code[1:0], any, start level, end level}
  localparam logic [9:0] VEC [NV] = '{
    {5'd0,  2'd2, 1'b0, 1'b0, 1'b1},
    {5'd17, 2'd2, 1'b0, 1'b1, 1'b0},
    {5'd31, 2'd3, 1'b0, 1'b1, 1'b0},
    {5'd15, 2'd3, 1'b0, 1'b0, 1'b1},
    {5'd16, 2'd1, 1'b0, 1'b0, 1'b1},
    {5'd8,  2'd0, 1'b0, 1'b1, 1'b0},
    {5'd20, 2'd1, 1'b1, 1'b1, 1'b0},
    {5'd9,  2'd0, 1'b1, 1'b0, 1'b1},
    {5'd24, 2'd2, 1'b1, 1'b0, 1'b0},
    {5'd3,  2'd2, 1'b0, 1'b0, 1'b0},
    {5'd30, 2'd1, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '1, pin_out, pin_oe;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic expect_hit(input logic [1:0] code, input logic any,
                                      input logic s, input logic e);
    if (any) return s != e;
    case (code)
      2'd0:    return e == 1'b0;
      2'd1:    return e == 1'b1;
      2'd2:    return !s && e;
      default: return s && !e;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    // R1: outputs during reset
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    rst = 1'b0;
    idle(1);
    // R1: register contents after reset
    for (int a = 0; a < 8; a++) begin
      if (a == 2 || a == 6) continue;
      rd(6'(a * 4), v);
      chk("R1 reg", v, 32'h0);
    end
    idle(4);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v);
    chk("R8 clear all", v, 32'h0);

    // R2: data and direction
    wr(6'h00, 32'hA5C3_0F71);
    wr(6'h04, 32'h0F0F_F00F);
    idle(1);
    chk("R2 pin_out", pin_out, 32'hA5C3_0F71);
    chk("R2 pin_oe", pin_oe, 32'h0F0F_F00F);
    rd(6'h00, v); chk("R2 data rb", v, 32'hA5C3_0F71);
    rd(6'h04, v); chk("R2 dir rb", v, 32'h0F0F_F00F);
    wr(6'h00, 32'h0); wr(6'h04, 32'h0);

    // R3: pad status tracks pins, writes ignored
    pin_in = 32'hFFFF_0FFF;
    idle(4);
    rd(6'h08, v); chk("R3 pad", v, 32'hFFFF_0FFF);
    wr(6'h08, 32'h1234_5678);
    rd(6'h08, v); chk("R3 pad write ignored", v, 32'hFFFF_0FFF);
    pin_in = '1;
    idle(4);
    wr(6'h18, 32'hFFFF_FFFF);

    // R11: unmapped and misaligned reads
    rd(6'h20, v); chk("R11 unmapped", v, 32'h0);
    rd(6'h3C, v); chk("R11 unmapped top", v, 32'h0);
    wr(6'h14, 32'h0000_00FF);
    rd(6'h15, v); chk("R11 misaligned", v, 32'h0);
    rd(6'h14, v); chk("R11 aligned", v, 32'h0000_00FF);
    wr(6'h14, 32'h0);

    // table: R4 R6 R7 R9 R10
    for (int k = 0; k < NV; k++) begin
      logic [4:0]  p;
      logic [1:0]  code;
      logic        any, s, e, hit;
      logic [31:0] field;
      {p, code, any, s, e} = VEC[k];
      hit   = expect_hit(code, any, s, e);
      field = 32'(code) << (2 * (p % 16));
      if (p < 16) wr(6'h0C, field); else wr(6'h10, field);
      wr(6'h1C, 32'(any) << p);
      wr(6'h14, 32'h1 << p);
      pin_in[p] = s;
      idle(5);
      wr(6'h18, 32'hFFFF_FFFF);
      idle(1);
      pin_in[p] = e;
      idle(5);
      chk("R10 irq_lo", {31'h0, irq_lo}, {31'h0, hit && p < 16});
      chk("R10 irq_hi", {31'h0, irq_hi}, {31'h0, hit && p >= 16});
      rd(6'h18, v);
      chk(any ? "R7 any-change" : "R4 R6 trigger", v, 32'(hit) << p);
      wr(6'h14, 32'h0); wr(6'h0C, 32'h0); wr(6'h10, 32'h0); wr(6'h1C, 32'h0);
      pin_in = '1;
      idle(5);
      wr(6'h18, 32'hFFFF_FFFF);
    end

    // R5: low level refills on the cycle of a clear
    pin_in[3] = 1'b0;
    idle(5);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R5 level refill", v, 32'h0000_0008);
    pin_in[3] = 1'b1;
    idle(5);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R5 level gone", v, 32'h0);

    // R6: rising edge flags once, held until cleared
    wr(6'h0C, 32'h2 << 10);
    pin_in[5] = 1'b0;
    idle(5);
    wr(6'h18, 32'hFFFF_FFFF);
    pin_in[5] = 1'b1;
    idle(5);
    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R8 write zero keeps", v, 32'h0000_0020);
    // R9: pending while masked keeps line low
    chk("R9 masked line", {31'h0, irq_lo}, 32'h0);
    wr(6'h14, 32'h0000_0020);
    idle(2);
    chk("R9 unmasked line", {31'h0, irq_lo}, 32'h1);
    chk("R10 other half", {31'h0, irq_hi}, 32'h0);
    wr(6'h18, 32'h0000_0020);
    idle(2);
    rd(6'h18, v); chk("R6 single event", v, 32'h0);
    chk("R8 line drops", {31'h0, irq_lo}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule